// File: doc/BRIEF.md
# Slope-Road Coincidence Finder

The finder takes muon-chamber hits that have already been turned into a slope-road index. Each hit also carries a plane number, a strip number and a crossing identifier. There are eight planes: planes 0 to 3 have horizontal strips, planes 4 and 5 form the first stereo orientation (U), and planes 6 and 7 form the second (V). While a bunch crossing is open, every hit is written into a two-slot ring. The ring is addressed by crossing slot, road and plane.

A crossing strobe `bx_tick` closes the open slot, which then becomes the scan slot, and opens the other slot, which is cleared for reuse. At that moment every road of the closed slot is tested against a programmable coincidence: a minimum number of horizontal planes, a minimum number of stereo planes, and a choice of whether U and V must both be present or either one is enough. Roads that pass are sent one per clock, in ascending road order. Each one goes out as a track strobe with the member-plane mask, and the strip and crossing ID of every member, to a downstream fitter that is shared among many finders. Consecutive `bx_tick` pulses must be at least `N_ROADS+1` cycles apart so that the matches of one crossing can drain.

Top module: `slope_road_finder`

## Requirements
- R1: After reset, `trk_stb` is low and the ring holds no hits, so a crossing closed without any hit produces no track.
- R2: A hit with `hit_valid` high is stored at its road and plane in the open crossing; a hit presented in the same cycle as `bx_tick` belongs to the newly opened crossing.
- R3: At `bx_tick` a road matches when its number of occupied horizontal planes (0 to 3) is at least `cfg_min_x` and its number of occupied stereo planes (4 to 7) is at least `cfg_min_uv`.
- R4: The stereo rule also applies: with `cfg_uv_and`=1 a match needs at least one U plane (4 or 5) and at least one V plane (6 or 7); with `cfg_uv_and`=0 at least one plane of either kind is needed.
- R5: When a plane of a road receives a second hit in the same crossing, the first hit's strip and crossing ID are kept.
- R6: Hits of one crossing never count toward the coincidence of any later crossing, including the crossing that reuses their slot two strobes later.
- R7: Matching roads of one crossing are output in ascending road order, one `trk_stb` cycle per road. Each road appears exactly once, and the first appears in the second cycle after the `bx_tick` cycle.
- R8: With `trk_stb` high, `trk_road` is the road, bit p of `trk_mask` marks plane p as a member, and bits [p*STRIP_W +: STRIP_W] of `trk_strip` and [p*BCID_W +: BCID_W] of `trk_bcid` carry that member's strip and crossing ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_tick | input | 1 | Closes the open crossing and opens the next |
| hit_valid | input | 1 | Hit present this cycle |
| hit_road | input | $clog2(N_ROADS) | Slope-road index of the hit |
| hit_plane | input | 3 | Plane number (0-3 horizontal, 4-5 U, 6-7 V) |
| hit_strip | input | STRIP_W | Strip number of the hit |
| hit_bcid | input | BCID_W | Crossing ID of the hit |
| cfg_min_x | input | 3 | Minimum horizontal planes |
| cfg_min_uv | input | 3 | Minimum stereo planes |
| cfg_uv_and | input | 1 | 1: U and V both needed; 0: either |
| trk_stb | output | 1 | Track strobe, one cycle per track |
| trk_road | output | $clog2(N_ROADS) | Road of the track |
| trk_mask | output | 8 | Member planes of the track |
| trk_strip | output | 8*STRIP_W | Member strips, plane p at p*STRIP_W |
| trk_bcid | output | 8*BCID_W | Member crossing IDs, plane p at p*BCID_W |

## Verification
The bench builds the finder with its defaults: 8 roads, 6-bit strips and 4-bit crossing IDs. With eight roads, one crossing can fill several roads out of order and the whole ascending drain fits in a short gap between strobes. The scenarios switch the thresholds and the U/V mode between crossings. They exercise the first-hit rule, the hit that arrives together with a strobe, and a partial road whose slot is reused two crossings later. A reference model built from the requirements predicts each track, and any strobe it did not predict counts as a failure.

// File: rtl/slope_road_finder_pkg.sv
`timescale 1ns/1ps
package slope_road_finder_pkg;
    localparam int NPL      = 8;
    localparam int PLANE_W  = 3;
    localparam int X_LO     = 0;
    localparam int X_HI     = 3;
    localparam int U_LO     = 4;
    localparam int U_HI     = 5;
    localparam int V_LO     = 6;
    localparam int V_HI     = 7;
    localparam int CNT_W    = 3;
endpackage

// File: rtl/rf_road_eval.sv
`timescale 1ns/1ps
module rf_road_eval
    import slope_road_finder_pkg::*;
#(
    parameter int N_ROADS = 8
) (
    input  logic [N_ROADS-1:0][NPL-1:0] occ,
    input  logic [CNT_W-1:0]            min_x,
    input  logic [CNT_W-1:0]            min_uv,
    input  logic                        uv_and,
    output logic [N_ROADS-1:0]          match
);
    for (genvar r = 0; r < N_ROADS; r++) begin : g_road
        logic [CNT_W-1:0] n_x;
        logic [CNT_W-1:0] n_u;
        logic [CNT_W-1:0] n_v;
        logic             stereo_ok;

        always_comb begin
            n_x = CNT_W'($countones(occ[r][X_HI:X_LO]));
            n_u = CNT_W'($countones(occ[r][U_HI:U_LO]));
            n_v = CNT_W'($countones(occ[r][V_HI:V_LO]));
            stereo_ok = uv_and ? ((n_u != '0) && (n_v != '0))
                               : ((n_u != '0) || (n_v != '0));
            match[r] = (n_x >= min_x) && ((n_u + n_v) >= min_uv) && stereo_ok;
        end
    end
endmodule

// File: rtl/rf_pick.sv
`timescale 1ns/1ps
module rf_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        onehot = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/slope_road_finder.sv
`timescale 1ns/1ps
module slope_road_finder
    import slope_road_finder_pkg::*;
#(
    parameter int N_ROADS = 8,
    parameter int STRIP_W = 6,
    parameter int BCID_W  = 4,
    localparam int RW     = (N_ROADS > 1) ? $clog2(N_ROADS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bx_tick,
    input  logic                    hit_valid,
    input  logic [RW-1:0]           hit_road,
    input  logic [PLANE_W-1:0]      hit_plane,
    input  logic [STRIP_W-1:0]      hit_strip,
    input  logic [BCID_W-1:0]       hit_bcid,
    input  logic [CNT_W-1:0]        cfg_min_x,
    input  logic [CNT_W-1:0]        cfg_min_uv,
    input  logic                    cfg_uv_and,
    output logic                    trk_stb,
    output logic [RW-1:0]           trk_road,
    output logic [NPL-1:0]          trk_mask,
    output logic [NPL*STRIP_W-1:0]  trk_strip,
    output logic [NPL*BCID_W-1:0]   trk_bcid
);
    typedef struct packed {
        logic                                         wr_slot;
        logic [1:0][N_ROADS-1:0][NPL-1:0]             vld;
        logic [1:0][N_ROADS-1:0][NPL-1:0][STRIP_W-1:0] strip;
        logic [1:0][N_ROADS-1:0][NPL-1:0][BCID_W-1:0]  bcid;
        logic [N_ROADS-1:0]                           pend;
        logic                                         out_stb;
        logic [RW-1:0]                                out_road;
        logic [NPL-1:0]                               out_mask;
        logic [NPL-1:0][STRIP_W-1:0]                  out_strip;
        logic [NPL-1:0][BCID_W-1:0]                   out_bcid;
    } state_t;

    state_t st_d, st_q;

    logic [N_ROADS-1:0][NPL-1:0] open_occ;
    logic [N_ROADS-1:0]          road_match;
    logic                        pick_any;
    logic [RW-1:0]               pick_idx;
    logic [N_ROADS-1:0]          pick_onehot;
    logic                        scan_slot;
    logic                        fill_slot;
    logic                        road_ok;

    assign open_occ  = st_q.vld[st_q.wr_slot];
    assign scan_slot = ~st_q.wr_slot;
    assign fill_slot = bx_tick ? ~st_q.wr_slot : st_q.wr_slot;
    assign road_ok   = (int'(hit_road) < N_ROADS);

    rf_road_eval #(.N_ROADS(N_ROADS)) u_eval (
        .occ    (open_occ),
        .min_x  (cfg_min_x),
        .min_uv (cfg_min_uv),
        .uv_and (cfg_uv_and),
        .match  (road_match)
    );

    rf_pick #(.N(N_ROADS)) u_pick (
        .req    (st_q.pend),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_stb = 1'b0;

        // drain one matched road of the scan slot per clock, lowest first
        if (pick_any) begin
            st_d.out_stb   = 1'b1;
            st_d.out_road  = pick_idx;
            st_d.out_mask  = st_q.vld[scan_slot][pick_idx];
            st_d.out_strip = st_q.strip[scan_slot][pick_idx];
            st_d.out_bcid  = st_q.bcid[scan_slot][pick_idx];
            st_d.pend      = st_q.pend & ~pick_onehot;
        end

        // crossing boundary: close open slot, evaluate it, clear the reused slot
        if (bx_tick) begin
            st_d.wr_slot                = ~st_q.wr_slot;
            st_d.vld[~st_q.wr_slot]     = '0;
            st_d.pend                   = road_match;
        end

        // store a hit; the first hit on a plane of a road is kept
        if (hit_valid && road_ok && !st_d.vld[fill_slot][hit_road][hit_plane]) begin
            st_d.vld[fill_slot][hit_road][hit_plane]   = 1'b1;
            st_d.strip[fill_slot][hit_road][hit_plane] = hit_strip;
            st_d.bcid[fill_slot][hit_road][hit_plane]  = hit_bcid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trk_stb   = st_q.out_stb;
    assign trk_road  = st_q.out_road;
    assign trk_mask  = st_q.out_mask;
    assign trk_strip = st_q.out_strip;
    assign trk_bcid  = st_q.out_bcid;
endmodule

// File: rtl/slope_road_finder_chk.sv
`timescale 1ns/1ps
module slope_road_finder_chk #(
    parameter int N_ROADS = 8,
    localparam int RW = (N_ROADS > 1) ? $clog2(N_ROADS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bx_tick,
    input logic               trk_stb,
    input logic [RW-1:0]      trk_road,
    input logic [7:0]         trk_mask,
    input logic [N_ROADS-1:0] pend
);
    // R8: a strobed track always has member planes
    a_r8_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        trk_stb |-> (trk_mask != '0));

    // R7: within one crossing the roads come out strictly ascending
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_stb && $past(trk_stb) && !$past(bx_tick)) |-> (trk_road > $past(trk_road)));

    // R7: every strobe comes from a pending match
    a_r7_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        trk_stb |-> $past(pend != '0));

    // R7: without a crossing strobe exactly one pending road retires per clock
    a_r7_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bx_tick) && ($past(pend) != '0)) |->
            ($countones(pend) == $countones($past(pend)) - 1));

    // R6: pending matches only appear at a crossing boundary
    a_r6_no_new_match_midcrossing: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bx_tick) |-> ((pend & ~$past(pend)) == '0));
endmodule

bind slope_road_finder slope_road_finder_chk #(.N_ROADS(N_ROADS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bx_tick  (bx_tick),
    .trk_stb  (trk_stb),
    .trk_road (trk_road),
    .trk_mask (trk_mask),
    .pend     (st_q.pend)
);

// File: tb/slope_road_finder_tb.sv
`timescale 1ns/1ps
module slope_road_finder_tb;
    localparam int NR = 8;
    localparam int SW = 6;
    localparam int BW = 4;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bx_tick = 1'b0;
    logic hit_valid = 1'b0;
    logic [RW-1:0] hit_road = '0;
    logic [2:0] hit_plane = '0;
    logic [SW-1:0] hit_strip = '0;
    logic [BW-1:0] hit_bcid = '0;
    logic [2:0] cfg_min_x = 3'd2;
    logic [2:0] cfg_min_uv = 3'd1;
    logic cfg_uv_and = 1'b0;
    logic trk_stb;
    logic [RW-1:0] trk_road;
    logic [7:0] trk_mask;
    logic [8*SW-1:0] trk_strip;
    logic [8*BW-1:0] trk_bcid;

    always #2.5 clk = ~clk;

    slope_road_finder #(.N_ROADS(NR), .STRIP_W(SW), .BCID_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .hit_valid(hit_valid),
        .hit_road(hit_road), .hit_plane(hit_plane), .hit_strip(hit_strip),
        .hit_bcid(hit_bcid), .cfg_min_x(cfg_min_x), .cfg_min_uv(cfg_min_uv),
        .cfg_uv_and(cfg_uv_and), .trk_stb(trk_stb), .trk_road(trk_road),
        .trk_mask(trk_mask), .trk_strip(trk_strip), .trk_bcid(trk_bcid)
    );

    typedef struct packed {
        logic [RW-1:0]   road;
        logic [7:0]      mask;
        logic [8*SW-1:0] strip;
        logic [8*BW-1:0] bcid;
    } trk_t;

    trk_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    string tag = "R1";

    // reference crossing accumulator
    logic [NR-1:0][7:0]         m_vld;
    logic [NR-1:0][7:0][SW-1:0] m_strip;
    logic [NR-1:0][7:0][BW-1:0] m_bcid;

    function automatic bit model_match(logic [7:0] m);
        int nx = 0, nu = 0, nv = 0;
        for (int p = 0; p < 4; p++) nx += int'(m[p]);
        for (int p = 4; p < 6; p++) nu += int'(m[p]);
        for (int p = 6; p < 8; p++) nv += int'(m[p]);
        if (nx < int'(cfg_min_x)) return 0;
        if (nu + nv < int'(cfg_min_uv)) return 0;
        if (cfg_uv_and) return (nu > 0) && (nv > 0);
        return (nu + nv) > 0;
    endfunction

    task automatic model_close();
        for (int r = 0; r < NR; r++) begin
            if (model_match(m_vld[r])) begin
                trk_t t;
                t.road  = RW'(r);
                t.mask  = m_vld[r];
                t.strip = m_strip[r];
                t.bcid  = m_bcid[r];
                exp_q.push_back(t);
            end
        end
        m_vld = '0;
    endtask

    task automatic model_hit(int r, int p, int s, int b);
        if (!m_vld[r][p]) begin
            m_vld[r][p]   = 1'b1;
            m_strip[r][p] = SW'(s);
            m_bcid[r][p]  = BW'(b);
        end
    endtask

    task automatic put_hit(int r, int p, int s, int b);
        @(negedge clk);
        hit_valid = 1'b1; hit_road = RW'(r); hit_plane = 3'(p);
        hit_strip = SW'(s); hit_bcid = BW'(b);
        model_hit(r, p, s, b);
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        bx_tick = 1'b1;
        model_close();
        @(negedge clk);
        bx_tick = 1'b0;
    endtask

    task automatic tick_with_hit(int r, int p, int s, int b);
        @(negedge clk);
        bx_tick = 1'b1;
        model_close();
        hit_valid = 1'b1; hit_road = RW'(r); hit_plane = 3'(p);
        hit_strip = SW'(s); hit_bcid = BW'(b);
        model_hit(r, p, s, b);
        @(negedge clk);
        bx_tick = 1'b0; hit_valid = 1'b0;
    endtask

    task automatic drain_check();
        repeat (NR + 4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d expected tracks missing (actual 0 strobes, expected %0d)",
                     tag, exp_q.size(), exp_q.size());
            exp_q.delete();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && trk_stb) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL %s: unexpected track road %0d mask %h (expected none)",
                         tag, trk_road, trk_mask);
            end else begin
                trk_t e;
                bit ok;
                e = exp_q.pop_front();
                n_checks++;
                if (trk_road != e.road) begin   // R7 order
                    n_fail++;
                    $display("FAIL R7 (%s): road actual %0d expected %0d", tag, trk_road, e.road);
                end
                n_checks++;
                ok = (trk_mask == e.mask);
                for (int p = 0; p < 8; p++) begin
                    if (e.mask[p]) begin
                        if (trk_strip[p*SW +: SW] != e.strip[p*SW +: SW]) ok = 0;
                        if (trk_bcid[p*BW +: BW] != e.bcid[p*BW +: BW]) ok = 0;
                    end
                end
                if (!ok) begin                  // R8 content
                    n_fail++;
                    $display("FAIL R8 (%s): mask/strip/bcid actual %h/%h/%h expected %h/%h/%h",
                             tag, trk_mask, trk_strip, trk_bcid, e.mask, e.strip, e.bcid);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_vld = '0; m_strip = '0; m_bcid = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and an empty crossing
        tag = "R1";
        n_checks++;
        if (trk_stb !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: trk_stb actual %b expected 0", trk_stb);
        end
        tick();
        drain_check();

        // R3: full eight-plane track with the strictest thresholds
        tag = "R3";
        cfg_min_x = 3'd4; cfg_min_uv = 3'd4; cfg_uv_and = 1'b1;
        for (int p = 0; p < 8; p++) put_hit(3, p, 10 + p, 5);
        tick();
        drain_check();

        // R4: 2X + U only, OR mode matches, AND mode does not
        tag = "R4";
        cfg_min_x = 3'd2; cfg_min_uv = 3'd1; cfg_uv_and = 1'b0;
        put_hit(5, 0, 1, 2); put_hit(5, 1, 2, 2); put_hit(5, 4, 3, 2);
        tick();
        drain_check();
        cfg_uv_and = 1'b1;
        put_hit(5, 0, 1, 3); put_hit(5, 1, 2, 3); put_hit(5, 4, 3, 3);
        tick();
        drain_check();
        cfg_uv_and = 1'b0;

        // R5: second hit on the same plane is discarded
        tag = "R5";
        put_hit(2, 0, 7, 4); put_hit(2, 0, 9, 6); put_hit(2, 2, 11, 4); put_hit(2, 6, 12, 4);
        tick();
        drain_check();

        // R7: several roads in one crossing, entered out of order
        tag = "R7";
        put_hit(6, 0, 20, 1); put_hit(1, 0, 21, 1); put_hit(4, 0, 22, 1);
        put_hit(6, 1, 23, 1); put_hit(1, 1, 24, 1); put_hit(4, 1, 25, 1);
        put_hit(4, 5, 26, 1); put_hit(6, 5, 27, 1); put_hit(1, 5, 28, 1);
        tick();
        drain_check();

        // R3: horizontal count below threshold
        tag = "R3";
        cfg_min_x = 3'd3;
        put_hit(0, 0, 1, 1); put_hit(0, 1, 1, 1); put_hit(0, 4, 1, 1); put_hit(0, 6, 1, 1);
        tick();
        drain_check();
        cfg_min_x = 3'd2;

        // R6: partial road split across crossings that share a slot
        tag = "R6";
        put_hit(7, 0, 30, 8); put_hit(7, 1, 31, 8);
        tick();
        drain_check();
        tick();
        drain_check();
        put_hit(7, 4, 32, 10);
        tick();
        drain_check();

        // R2: hit presented with the strobe opens the next crossing
        tag = "R2";
        put_hit(4, 0, 40, 11); put_hit(4, 1, 41, 11);
        tick_with_hit(4, 6, 42, 12);
        drain_check();
        put_hit(4, 2, 43, 12); put_hit(4, 3, 44, 12);
        tick();
        drain_check();

        // R3: stereo count threshold
        tag = "R3";
        cfg_min_x = 3'd1; cfg_min_uv = 3'd3; cfg_uv_and = 1'b0;
        put_hit(1, 0, 50, 13); put_hit(1, 4, 51, 13); put_hit(1, 5, 52, 13); put_hit(1, 6, 53, 13);
        put_hit(2, 0, 54, 13); put_hit(2, 4, 55, 13); put_hit(2, 6, 56, 13);
        tick();
        drain_check();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule